// File: doc/BRIEF.md
# Fault Interrupt Status Controller

This block gathers fault events from the power-rail monitors of a supply subsystem. It holds them in two status registers and raises an active-low, open-drain interrupt request towards a host processor. Each fault input is a level that is high while its condition is present. A rising level latches the matching status bit. A fault that is still present after the host has cleared its bit is latched again by a free-running re-arm timer, so the host cannot lose an event that has not gone away.

The host reaches the block through a simple parallel register port with a read strobe, a write strobe and a two-bit address. A read of a status register returns its contents and clears that register. Two enable registers choose which latched bits may pull the interrupt line. They have no effect on what the status registers capture. The open-drain pin is modelled as an output-enable that is high whenever the pin is to be pulled low.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After a synchronous reset, both status registers, both enable registers, the read-data output and the interrupt output-enable are all zero.
- R2: A rising edge on fault input bit i of group A (or B) sets bit i of status register A (or B). The set is visible on the status output after the clock edge that samples the rise, whatever the enable bits hold.
- R3: A status bit that is set stays set until its own register is read. A read of the other register leaves it unchanged.
- R4: A read strobe with address 0 (status A) or 1 (status B) returns that register's current value on reg_rdata_o after the sampling edge. The same edge clears every bit of that register. reg_rdata_o holds its value while no read is made.
- R5: When a fault rise and a read of the same register fall in the same cycle, the rising bit remains set after the read.
- R6: While a fault input stays high, its status bit is set again no later than REARM_TICKS clock cycles after a read cleared it. The default of 6400 cycles equals 32 us at 200 MHz.
- R7: irq_oe_o is high exactly when some status bit and its matching enable bit are both set. It changes on the same clock edge as the status registers.
- R8: A write with address 2 loads enable register A and a write with address 3 loads enable register B. Reading those addresses returns the value written. A cleared enable bit keeps its event off irq_oe_o but the status bit is still captured.
- R9: Writes with address 0 or 1 leave both status registers unchanged.
- R10: A fault that has returned low before its bit is read is not set again after the read, however long the wait.
- R11: Four separate rail undervoltage faults enter on fault_a_i bits 0 to 3, and each sets only its own status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fault_a_i | input | W | Fault levels for status group A (bits 0 to 3 are rail undervoltage) |
| fault_b_i | input | W | Fault levels for status group B |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status A, 1 status B, 2 enable A, 3 enable B |
| reg_wdata_i | input | W | Write data |
| reg_rdata_o | output | W | Registered read data |
| status_a_o | output | W | Status register A contents |
| status_b_o | output | W | Status register B contents |
| irq_oe_o | output | 1 | High to pull the active-low interrupt pin low |

## Verification
Random single-cycle fault pulses on both groups are mixed with random reads, writes and addresses. This exercises the set-versus-clear ordering and the enable gating of the interrupt against a bench model cycle by cycle. Because the pulses never last two cycles, that phase shows whether the edge path alone captures events. Directed cases then hold a fault high across a read, to show that the re-arm path re-latches it, and drop a fault before a read, to show that stale events are not re-latched. Further directed cases put a rise on the same edge as a clearing read to settle their priority, and write to the status addresses to show that such writes are ignored.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

  typedef enum logic [1:0] {
    SEL_STAT_A = 2'd0,
    SEL_STAT_B = 2'd1,
    SEL_EN_A   = 2'd2,
    SEL_EN_B   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/fault_irq_rearm.sv
module fault_irq_rearm #(
  parameter int TICKS = 6400
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fault_irq_bank.sv
module fault_irq_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] fault_i,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         irq_req_o
);
  logic [W-1:0] prev_q, status_q, enable_q;
  logic [W-1:0] rise_w, set_w, status_d, enable_d;

  // Edge path catches new events; tick path re-latches persisting ones.
  assign rise_w   = fault_i & ~prev_q;
  assign set_w    = rise_w | (fault_i & {W{tick_i}});
  // Set wins over the clear of a read in the same cycle.
  assign status_d = (status_q & ~{W{clr_i}}) | set_w;
  assign enable_d = en_we_i ? en_wdata_i : enable_q;

  // Request from next-state values so the registered pin lines up with status.
  assign irq_req_o = |(status_d & enable_d);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q   <= '0;
      status_q <= '0;
      enable_q <= '0;
    end else begin
      prev_q   <= fault_i;
      status_q <= status_d;
      enable_q <= enable_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int W           = 8,
  parameter int REARM_TICKS = 6400
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] fault_a_i,
  input  logic [W-1:0] fault_b_i,
  input  logic         reg_rd_i,
  input  logic         reg_wr_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic [W-1:0] status_a_o,
  output logic [W-1:0] status_b_o,
  output logic         irq_oe_o
);
  localparam int NUM_BANKS = 2;

  logic [NUM_BANKS-1:0][W-1:0] fault_w;
  logic [NUM_BANKS-1:0][W-1:0] status_w;
  logic [NUM_BANKS-1:0][W-1:0] enable_w;
  logic [NUM_BANKS-1:0]        irq_req_w;
  logic                        tick_w;
  reg_sel_e                    sel_w;
  logic [W-1:0]                rdata_q;
  logic                        irq_q;

  assign fault_w[0] = fault_a_i;
  assign fault_w[1] = fault_b_i;
  assign sel_w      = reg_sel_e'(reg_addr_i);

  fault_irq_rearm #(.TICKS(REARM_TICKS)) rearm_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_o (tick_w)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic clr_w, we_w;
    assign clr_w = reg_rd_i && (reg_addr_i == 2'(g));
    assign we_w  = reg_wr_i && (reg_addr_i == 2'(g + NUM_BANKS));

    fault_irq_bank #(.W(W)) bank_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .fault_i    (fault_w[g]),
      .tick_i     (tick_w),
      .clr_i      (clr_w),
      .en_we_i    (we_w),
      .en_wdata_i (reg_wdata_i),
      .status_o   (status_w[g]),
      .enable_o   (enable_w[g]),
      .irq_req_o  (irq_req_w[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |irq_req_w;
      if (reg_rd_i) begin
        case (sel_w)
          SEL_STAT_A: rdata_q <= status_w[0];
          SEL_STAT_B: rdata_q <= status_w[1];
          SEL_EN_A:   rdata_q <= enable_w[0];
          default:    rdata_q <= enable_w[1];
        endcase
      end
    end
  end

  assign reg_rdata_o = rdata_q;
  assign status_a_o  = status_w[0];
  assign status_b_o  = status_w[1];
  assign irq_oe_o    = irq_q;
endmodule

// File: rtl/fault_irq_ctrl_chk.sv
module fault_irq_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic [W-1:0] fault_a_i,
  input logic [W-1:0] fault_b_i,
  input logic         reg_rd_i,
  input logic [1:0]   reg_addr_i,
  input logic [W-1:0] status_a_o,
  input logic [W-1:0] status_b_o,
  input logic         irq_oe_o,
  input logic [W-1:0] en_a_i,
  input logic [W-1:0] en_b_i
);
  logic         rst_d;
  logic [W-1:0] fa_q, fb_q, rise_a, rise_b;

  always_ff @(posedge clk_i) begin
    rst_d <= rst_i;
    if (rst_i) begin
      fa_q <= '0;
      fb_q <= '0;
    end else begin
      fa_q <= fault_a_i;
      fb_q <= fault_b_i;
    end
  end

  assign rise_a = fault_a_i & ~fa_q;
  assign rise_b = fault_b_i & ~fb_q;

  // R1: first cycle after reset shows cleared state
  always_ff @(posedge clk_i) begin
    if (rst_d === 1'b1 && rst_i === 1'b0) begin
      assert_reset_clear_R1: assert (status_a_o == '0 && status_b_o == '0 && !irq_oe_o);
    end
  end

  assert_rise_sets_a_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_a != '0) |=> ((status_a_o & $past(rise_a)) == $past(rise_a)));

  assert_rise_sets_b_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_b != '0) |=> ((status_b_o & $past(rise_b)) == $past(rise_b)));

  assert_hold_a_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !(reg_rd_i && reg_addr_i == 2'd0) |=> ((status_a_o & $past(status_a_o)) == $past(status_a_o)));

  assert_hold_b_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !(reg_rd_i && reg_addr_i == 2'd1) |=> ((status_b_o & $past(status_b_o)) == $past(status_b_o)));

  assert_irq_level_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_oe_o == (|((status_a_o & en_a_i) | (status_b_o & en_b_i))));
endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk #(.W(W)) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .fault_a_i  (fault_a_i),
  .fault_b_i  (fault_b_i),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .status_a_o (status_a_o),
  .status_b_o (status_b_o),
  .irq_oe_o   (irq_oe_o),
  .en_a_i     (enable_w[0]),
  .en_b_i     (enable_w[1])
);

// File: tb/fault_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fault_irq_ctrl_tb_top;
  localparam int W     = 8;
  localparam int REARM = 40;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] fault_a, fault_b, wdata;
  logic         rd, wr;
  logic [1:0]   addr;
  logic [W-1:0] rdata, stat_a, stat_b;
  logic         irq;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  fault_irq_ctrl #(.W(W), .REARM_TICKS(REARM)) dut_i (
    .clk_i(clk), .rst_i(rst), .fault_a_i(fault_a), .fault_b_i(fault_b),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .status_a_o(stat_a), .status_b_o(stat_b), .irq_oe_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic irq_of(input logic [W-1:0] sa, ea, sb, eb);
    return |((sa & ea) | (sb & eb));
  endfunction

  function automatic logic [W-1:0] next_stat(input logic [W-1:0] s, rise, input logic clr);
    return (clr ? '0 : s) | rise;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    fault_a = '0; fault_b = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_a(input logic [W-1:0] m);
    @(negedge clk); fault_a = m;
    @(negedge clk); fault_a = '0;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [W-1:0] es_a, es_b, ee_a, ee_b, erd, pa, pb, d;
    logic         eirq, seen;
    void'($urandom(32'h5eed_1a2b));
    do_reset();

    // Random phase: single-cycle fault pulses, random register traffic
    es_a = '0; es_b = '0; ee_a = '0; ee_b = '0; erd = '0; eirq = 1'b0;
    pa = '0; pb = '0;
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] ra, rb, na, nb;
      logic         r, w;
      logic [1:0]   ad;
      logic [W-1:0] wd;
      @(negedge clk);
      check("R2/R3 status A", stat_a, es_a);
      check("R2/R3 status B", stat_b, es_b);
      check("R4/R8 rdata", rdata, erd);
      check("R7 irq", irq, eirq);
      na = W'($urandom & $urandom & $urandom) & ~pa;
      nb = W'($urandom & $urandom & $urandom) & ~pb;
      r  = ($urandom % 3) == 0;
      w  = ($urandom % 4) == 0;
      ad = 2'($urandom % 4);
      wd = W'($urandom);
      fault_a = na; fault_b = nb; rd = r; wr = w; addr = ad; wdata = wd;
      ra = na & ~pa; rb = nb & ~pb;
      if (r) begin
        case (ad)
          2'd0: erd = es_a;
          2'd1: erd = es_b;
          2'd2: erd = ee_a;
          default: erd = ee_b;
        endcase
      end
      es_a = next_stat(es_a, ra, r && ad == 2'd0);
      es_b = next_stat(es_b, rb, r && ad == 2'd1);
      if (w && ad == 2'd2) ee_a = wd;
      if (w && ad == 2'd3) ee_b = wd;
      eirq = irq_of(es_a, ee_a, es_b, ee_b);
      pa = na; pb = nb;
    end

    // Directed phase
    do_reset();
    @(negedge clk);
    check("R1 status A", stat_a, 0);
    check("R1 status B", stat_b, 0);
    check("R1 rdata", rdata, 0);
    check("R1 irq", irq, 0);
    do_read(2'd2, d);
    check("R1 enable A", d, 0);
    do_read(2'd3, d);
    check("R1 enable B", d, 0);

    // R11: four rail undervoltage bits, each its own
    for (int k = 0; k < 4; k++) begin
      pulse_a(W'(1) << k);
      check("R11 rail bit", stat_a, W'(1) << k);
      do_read(2'd0, d);
      check("R11 rail readback", d, W'(1) << k);
    end

    // R8: masked event still captured, no interrupt
    pulse_a(8'h02);
    check("R8 masked capture", stat_a, 8'h02);
    check("R8 masked no irq", irq, 0);
    do_write(2'd2, 8'h02);
    check("R7 irq after enable", irq, 1);
    do_read(2'd2, d);
    check("R8 enable readback", d, 8'h02);

    // R9: writes to status addresses ignored
    do_write(2'd0, 8'h00);
    do_write(2'd1, 8'hff);
    check("R9 status A kept", stat_a, 8'h02);
    check("R9 status B kept", stat_b, 0);

    // R3: read of B does not touch A
    do_read(2'd1, d);
    check("R3 A kept over B read", stat_a, 8'h02);

    // R4: read clears and releases irq
    do_read(2'd0, d);
    check("R4 read value", d, 8'h02);
    check("R4 cleared", stat_a, 0);
    check("R4 irq released", irq, 0);

    // R6: persisting fault re-latched within REARM cycles
    do_write(2'd2, 8'h0f);
    @(negedge clk); fault_a = 8'h04;
    repeat (2) @(negedge clk);
    do_read(2'd0, d);
    check("R6 first read", d, 8'h04);
    seen = 1'b0;
    for (int c = 0; c < REARM; c++) begin
      if (stat_a[2] && irq) seen = 1'b1;
      if (!seen) @(negedge clk);
    end
    if (stat_a[2] && irq) seen = 1'b1;
    check("R6 re-latched", seen, 1);

    // R10: fault gone before read, never re-latched
    @(negedge clk); fault_a = '0;
    do_read(2'd0, d);
    repeat (2 * REARM) @(negedge clk);
    check("R10 stays clear", stat_a, 0);
    check("R10 irq clear", irq, 0);

    // R5: rise coincides with clearing read
    pulse_a(8'h40);
    @(negedge clk); rd = 1'b1; addr = 2'd0; fault_a = 8'h40;
    @(negedge clk); rd = 1'b0; fault_a = '0;
    check("R5 read value", rdata, 8'h40);
    check("R5 bit stays set", stat_a, 8'h40);

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule